// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block sequences a processor core through its low-power modes. It keeps one of five power states and moves between them on a halt strobe, an active-low stop-clock request, the interrupt lines, hard and soft reset, an active-low snoop strobe and a clock-valid indication. On the transitions that need one, it issues single-cycle requests to the bus cycle engine: one for a stop-grant cycle and one for a halt cycle. It also issues a single-cycle request to the cache for a line invalidation.

The block also gates interrupt recognition. Interrupt activity seen while the clocks are being stopped is not acted on. A line counts only if it is still active one clock after the core has left stop-grant. A registered recognition vector is presented for the three interrupt lines, and the INTR bit is held until an acknowledge pulse.

A clock guard counts how long the clock has been valid since it last dropped. If the stop-clock request is released before the clock has been stable for `STABLE_CYCLES` cycles after a stop, the guard sets a sticky violation flag. All ports are plain control pins with no handshake. Every input is sampled on the rising edge, and every output is a register.

Top module: `pwr_stopclk_ctrl`

## Requirements
- R1: After `rst_n` is low, `pwr_state` reads 0 and every strobe, `irq_recog` and `clk_violation` read 0. The state encoding is 0 normal, 1 auto-halt, 2 stop-grant, 3 stop-clock, 4 snoop.
- R2: In normal, with no stop request, `halt_stb` moves the state to auto-halt and raises `halt_cycle_stb` for exactly one cycle.
- R3: In auto-halt, with no stop request, any of `intr`, `nmi`, `smi`, `soft_rst` or `hard_rst` returns the state to normal.
- R4: `stop_req_n` low in normal or auto-halt moves the state to stop-grant and raises `sg_cycle_stb` for one cycle. This takes priority over the halt and wake inputs.
- R5: Re-entering stop-grant from stop-clock or from snoop raises no `sg_cycle_stb`.
- R6: `snoop_n` low in stop-grant or auto-halt moves the state to snoop, where `inval_stb` is high. The next cycle returns to the state that was left.
- R7: In stop-grant, `clk_valid` low moves the state to stop-clock. In stop-clock, `clk_valid` high moves it back to stop-grant.
- R8: After a visit to stop-clock, suppose `stop_req_n` rises at the edge where `clk_valid` has been sampled high on fewer than `STABLE_CYCLES` prior edges. Then `clk_violation` sets and stays set until `rst_n`. With at least `STABLE_CYCLES` samples, or with no stop-clock visit, it stays clear.
- R9: `irq_recog` bit 0 is INTR, bit 1 is NMI and bit 2 is SMI. A line is sampled into it only at edges where the state is normal or auto-halt. Activity during stop-grant or stop-clock is never recognized. A line still active at the second edge after the release appears then.
- R10: `irq_recog` bit 0 stays set after `intr` falls and clears at the edge that samples `intr_ack` high.
- R11: Releasing `stop_req_n` in stop-grant returns to the state the stop-grant was entered from. A return to auto-halt raises `halt_cycle_stb` again. A return to normal raises no strobe.
- R12: `snoop_n` low in stop-clock is ignored: the state stays stop-clock and `inval_stb` stays 0.
- R13: `hard_rst` forces normal from every state on the next edge and clears `irq_recog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| halt_stb | input | 1 | Halt instruction executed, one-cycle strobe |
| intr | input | 1 | Maskable interrupt line |
| nmi | input | 1 | Non-maskable interrupt line |
| smi | input | 1 | System management interrupt line |
| intr_ack | input | 1 | Interrupt acknowledge pulse |
| hard_rst | input | 1 | Hard core reset request |
| soft_rst | input | 1 | Soft core reset request |
| snoop_n | input | 1 | External snoop strobe, active low |
| clk_valid | input | 1 | Input clock running and in range |
| sg_cycle_stb | output | 1 | Request a stop-grant bus cycle |
| halt_cycle_stb | output | 1 | Request a halt bus cycle |
| inval_stb | output | 1 | Request a cache line invalidation |
| irq_recog | output | 3 | Recognized interrupts {smi, nmi, intr} |
| pwr_state | output | 3 | Current power state |
| clk_violation | output | 1 | Sticky early-release flag |

## Verification
Every result is one register away from its inputs. The state and the three strobes change at the first rising edge that samples a stimulus. `clk_violation` changes at the edge that samples the release. An interrupt line held across a release appears one edge after the state leaves stop-grant. The bench drives inputs on the falling edge and advances one rising edge before each check. It then samples on the following falling edge, so each check sits in the cycle that follows the counted edges. The stability sweep steps the gap between clock return and release across the threshold, and it predicts the flag as gap < `STABLE_CYCLES`.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN     = 3'd0,
    PS_HALT    = 3'd1,
    PS_GRANT   = 3'd2,
    PS_STOPPED = 3'd3,
    PS_SNOOP   = 3'd4
  } pwr_state_e;

  localparam int unsigned IRQ_LINES = 3;
  localparam int unsigned IRQ_INTR  = 0;
  localparam int unsigned IRQ_NMI   = 1;
  localparam int unsigned IRQ_SMI   = 2;

  function automatic logic is_awake(input pwr_state_e s);
    return (s == PS_RUN) || (s == PS_HALT);
  endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req_n,
  input  logic       halt_stb,
  input  logic       wake,
  input  logic       hard_rst,
  input  logic       snoop_n,
  input  logic       clk_valid,
  output pwr_state_e state_o,
  output logic       sg_stb_o,
  output logic       halt_bus_o,
  output logic       inval_o
);

  pwr_state_e state_q, state_d;
  pwr_state_e origin_q, origin_d;
  pwr_state_e back_q, back_d;
  logic sg_d, hb_d, inv_d;
  logic sg_q, hb_q, inv_q;

  always_comb begin
    state_d  = state_q;
    origin_d = origin_q;
    back_d   = back_q;
    sg_d     = 1'b0;
    hb_d     = 1'b0;
    inv_d    = 1'b0;
    if (hard_rst) begin
      state_d  = PS_RUN;
      origin_d = PS_RUN;
      back_d   = PS_RUN;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (!stop_req_n) begin
            state_d  = PS_GRANT;
            origin_d = PS_RUN;
            sg_d     = 1'b1;
          end else if (halt_stb) begin
            state_d = PS_HALT;
            hb_d    = 1'b1;
          end
        end
        PS_HALT: begin
          if (!stop_req_n) begin
            state_d  = PS_GRANT;
            origin_d = PS_HALT;
            sg_d     = 1'b1;
          end else if (wake) begin
            state_d = PS_RUN;
          end else if (!snoop_n) begin
            state_d = PS_SNOOP;
            back_d  = PS_HALT;
            inv_d   = 1'b1;
          end
        end
        PS_GRANT: begin
          if (!clk_valid) begin
            state_d = PS_STOPPED;
          end else if (stop_req_n) begin
            state_d = origin_q;
            hb_d    = (origin_q == PS_HALT);
          end else if (!snoop_n) begin
            state_d = PS_SNOOP;
            back_d  = PS_GRANT;
            inv_d   = 1'b1;
          end
        end
        PS_STOPPED: begin
          if (clk_valid) state_d = PS_GRANT;
        end
        PS_SNOOP: begin
          state_d = back_q;
        end
        default: state_d = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_RUN;
      origin_q <= PS_RUN;
      back_q   <= PS_RUN;
      sg_q     <= 1'b0;
      hb_q     <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      origin_q <= origin_d;
      back_q   <= back_d;
      sg_q     <= sg_d;
      hb_q     <= hb_d;
      inv_q    <= inv_d;
    end
  end

  assign state_o    = state_q;
  assign sg_stb_o   = sg_q;
  assign halt_bus_o = hb_q;
  assign inval_o    = inv_q;

  AST_HALT_STB_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    hb_q |-> state_q == PS_HALT); // R2
  AST_SG_STB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sg_q |-> (state_q == PS_GRANT) &&
             ($past(state_q) == PS_RUN || $past(state_q) == PS_HALT)); // R4
  AST_NO_SG_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOPPED || state_q == PS_SNOOP) |=> !sg_q); // R5
  AST_SNOOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PS_SNOOP |=> state_q != PS_SNOOP); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOPPED && !clk_valid && !hard_rst) |=> state_q == PS_STOPPED); // R12
  AST_HARD_RST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> state_q == PS_RUN); // R13

endmodule

// File: rtl/pwr_clk_guard.sv
module pwr_clk_guard
  import pwr_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 33333
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state_i,
  input  logic       stop_req_n,
  input  logic       clk_valid,
  output logic       violation_o
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [CW-1:0] stable_cnt_q;
  logic          disturbed_q;
  logic          viol_q;
  logic          early_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt_q <= '0;
    end else if (!clk_valid) begin
      stable_cnt_q <= '0;
    end else if (stable_cnt_q != LIMIT) begin
      stable_cnt_q <= stable_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disturbed_q <= 1'b0;
    end else if (state_i == PS_STOPPED) begin
      disturbed_q <= 1'b1;
    end else if (is_awake(state_i)) begin
      disturbed_q <= 1'b0;
    end
  end

  assign early_release = (state_i == PS_GRANT) && stop_req_n && clk_valid &&
                         disturbed_q && (stable_cnt_q < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
    end else if (early_release) begin
      viol_q <= 1'b1;
    end
  end

  assign violation_o = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q); // R8
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_valid |=> stable_cnt_q == '0); // R8

endmodule

// File: rtl/pwr_irq_gate.sv
module pwr_irq_gate
  import pwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pwr_state_e           state_i,
  input  logic [IRQ_LINES-1:0] lines_i,
  input  logic                 intr_ack,
  input  logic                 hard_rst,
  output logic [IRQ_LINES-1:0] recog_o
);

  logic                 open_w;
  logic [IRQ_LINES-1:0] recog_q;

  assign open_w = is_awake(state_i);

  genvar g;
  generate
    for (g = 0; g < IRQ_LINES; g++) begin : g_line
      if (g == IRQ_INTR) begin : g_held
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            recog_q[g] <= 1'b0;
          end else if (hard_rst || intr_ack) begin
            recog_q[g] <= 1'b0;
          end else if (open_w && lines_i[g]) begin
            recog_q[g] <= 1'b1;
          end
        end
      end else begin : g_level
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            recog_q[g] <= 1'b0;
          end else begin
            recog_q[g] <= !hard_rst && open_w && lines_i[g];
          end
        end
      end
    end
  endgenerate

  assign recog_o = recog_q;

  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    recog_q[IRQ_NMI] |-> $past(open_w)); // R9
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    recog_q[IRQ_SMI] |-> $past(open_w)); // R9
  AST_INTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (recog_q[IRQ_INTR] && !intr_ack && !hard_rst) |=> recog_q[IRQ_INTR]); // R10
  AST_HARD_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> recog_q == '0); // R13

endmodule

// File: rtl/pwr_stopclk_ctrl.sv
module pwr_stopclk_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 33333
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req_n,
  input  logic       halt_stb,
  input  logic       intr,
  input  logic       nmi,
  input  logic       smi,
  input  logic       intr_ack,
  input  logic       hard_rst,
  input  logic       soft_rst,
  input  logic       snoop_n,
  input  logic       clk_valid,
  output logic       sg_cycle_stb,
  output logic       halt_cycle_stb,
  output logic       inval_stb,
  output logic [2:0] irq_recog,
  output logic [2:0] pwr_state,
  output logic       clk_violation
);

  pwr_state_e           state_w;
  logic                 wake_w;
  logic [IRQ_LINES-1:0] lines_w;

  assign wake_w  = intr | nmi | smi | soft_rst;
  assign lines_w = {smi, nmi, intr};

  pwr_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req_n (stop_req_n),
    .halt_stb   (halt_stb),
    .wake       (wake_w),
    .hard_rst   (hard_rst),
    .snoop_n    (snoop_n),
    .clk_valid  (clk_valid),
    .state_o    (state_w),
    .sg_stb_o   (sg_cycle_stb),
    .halt_bus_o (halt_cycle_stb),
    .inval_o    (inval_stb)
  );

  pwr_clk_guard #(
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state_w),
    .stop_req_n  (stop_req_n),
    .clk_valid   (clk_valid),
    .violation_o (clk_violation)
  );

  pwr_irq_gate u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state_w),
    .lines_i  (lines_w),
    .intr_ack (intr_ack),
    .hard_rst (hard_rst),
    .recog_o  (irq_recog)
  );

  assign pwr_state = state_w;

  AST_INVAL_ONLY_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    inval_stb |-> pwr_state == 3'd4); // R6
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sg_cycle_stb, halt_cycle_stb, inval_stb}) <= 1); // R4

endmodule

// File: tb/test_pwr_stopclk_ctrl.sv
module test_pwr_stopclk_ctrl;

  localparam int unsigned STB = 8;

  logic clk = 1'b0;
  logic rst_n, stop_req_n, halt_stb, intr, nmi, smi, intr_ack;
  logic hard_rst, soft_rst, snoop_n, clk_valid;
  logic sg_cycle_stb, halt_cycle_stb, inval_stb, clk_violation;
  logic [2:0] irq_recog, pwr_state;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_stopclk_ctrl #(.STABLE_CYCLES(STB)) i_pwr_stopclk_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .halt_stb(halt_stb),
    .intr(intr), .nmi(nmi), .smi(smi), .intr_ack(intr_ack),
    .hard_rst(hard_rst), .soft_rst(soft_rst), .snoop_n(snoop_n),
    .clk_valid(clk_valid), .sg_cycle_stb(sg_cycle_stb),
    .halt_cycle_stb(halt_cycle_stb), .inval_stb(inval_stb),
    .irq_recog(irq_recog), .pwr_state(pwr_state), .clk_violation(clk_violation)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    stop_req_n = 1'b1; halt_stb = 1'b0; intr = 1'b0; nmi = 1'b0; smi = 1'b0;
    intr_ack = 1'b0; hard_rst = 1'b0; soft_rst = 1'b0; snoop_n = 1'b1;
    clk_valid = 1'b1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic enter_grant();
    stop_req_n = 1'b0;
    step();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 state", pwr_state, 0);
    chk("R1 strobes", {sg_cycle_stb, halt_cycle_stb, inval_stb}, 0);
    chk("R1 irq", irq_recog, 0);
    chk("R1 violation", clk_violation, 0);

    // R2 halt
    halt_stb = 1'b1; step(); halt_stb = 1'b0;
    chk("R2 state", pwr_state, 1);
    chk("R2 halt strobe", halt_cycle_stb, 1);
    step();
    chk("R2 strobe one cycle", halt_cycle_stb, 0);
    chk("R2 stays halted", pwr_state, 1);

    // R3 each wake source
    for (int src = 0; src < 5; src++) begin
      do_reset();
      halt_stb = 1'b1; step(); halt_stb = 1'b0;
      case (src)
        0: intr = 1'b1;
        1: nmi = 1'b1;
        2: smi = 1'b1;
        3: soft_rst = 1'b1;
        default: hard_rst = 1'b1;
      endcase
      step();
      chk($sformatf("R3 wake src %0d", src), pwr_state, 0);
      idle_inputs();
    end

    // R4 / R11 from normal
    do_reset();
    enter_grant();
    chk("R4 grant from normal", pwr_state, 2);
    chk("R4 sg strobe", sg_cycle_stb, 1);
    step();
    chk("R4 sg one cycle", sg_cycle_stb, 0);
    stop_req_n = 1'b1; step();
    chk("R11 back to normal", pwr_state, 0);
    chk("R11 no halt strobe", halt_cycle_stb, 0);
    chk("R8 no stop no violation", clk_violation, 0);

    // R4 priority over halt; R11 from auto-halt
    do_reset();
    halt_stb = 1'b1; stop_req_n = 1'b0; step(); halt_stb = 1'b0;
    chk("R4 stop beats halt", pwr_state, 2);
    do_reset();
    halt_stb = 1'b1; step(); halt_stb = 1'b0;
    enter_grant();
    chk("R4 grant from halt", pwr_state, 2);
    chk("R4 sg strobe from halt", sg_cycle_stb, 1);
    stop_req_n = 1'b1; step();
    chk("R11 back to halt", pwr_state, 1);
    chk("R11 halt strobe again", halt_cycle_stb, 1);

    // R7 / R12 / R5
    do_reset();
    enter_grant();
    clk_valid = 1'b0; step();
    chk("R7 stop-clock", pwr_state, 3);
    snoop_n = 1'b0; step(); snoop_n = 1'b1;
    chk("R12 snoop ignored state", pwr_state, 3);
    chk("R12 no invalidate", inval_stb, 0);
    clk_valid = 1'b1; step();
    chk("R7 back to grant", pwr_state, 2);
    chk("R5 no sg strobe from stop", sg_cycle_stb, 0);

    // R6 snoop in grant
    snoop_n = 1'b0; step(); snoop_n = 1'b1;
    chk("R6 snoop state", pwr_state, 4);
    chk("R6 invalidate", inval_stb, 1);
    step();
    chk("R6 return to grant", pwr_state, 2);
    chk("R5 no sg strobe from snoop", sg_cycle_stb, 0);
    chk("R6 invalidate one cycle", inval_stb, 0);

    // R6 snoop in auto-halt
    do_reset();
    halt_stb = 1'b1; step(); halt_stb = 1'b0;
    snoop_n = 1'b0; step(); snoop_n = 1'b1;
    chk("R6 snoop from halt", pwr_state, 4);
    step();
    chk("R6 return to halt", pwr_state, 1);
    chk("R6 no halt strobe on return", halt_cycle_stb, 0);

    // R8 stability sweep
    for (int gap = 1; gap <= int'(STB) + 2; gap++) begin
      do_reset();
      enter_grant();
      clk_valid = 1'b0; step();
      clk_valid = 1'b1; step();
      for (int w = 1; w < gap; w++) step();
      stop_req_n = 1'b1; step();
      chk($sformatf("R8 gap %0d", gap), clk_violation, (gap < int'(STB)) ? 1 : 0);
      chk($sformatf("R11 gap %0d state", gap), pwr_state, 0);
      step();
      chk($sformatf("R8 sticky gap %0d", gap), clk_violation, (gap < int'(STB)) ? 1 : 0);
    end

    // R9 pulses in grant are lost
    do_reset();
    enter_grant();
    intr = 1'b1; nmi = 1'b1; smi = 1'b1; step();
    intr = 1'b0; nmi = 1'b0; smi = 1'b0;
    chk("R9 blocked in grant", irq_recog, 0);
    step();
    stop_req_n = 1'b1; step();
    chk("R9 none at release", irq_recog, 0);
    step();
    chk("R9 pulses never seen", irq_recog, 0);

    // R9 held lines recognized one edge after release
    do_reset();
    enter_grant();
    nmi = 1'b1; smi = 1'b1; step();
    stop_req_n = 1'b1; step();
    chk("R9 not yet at release edge", irq_recog, 0);
    step();
    chk("R9 held lines seen", irq_recog, 6);
    nmi = 1'b0; smi = 1'b0; step();
    chk("R9 level follows", irq_recog, 0);

    // R10 INTR held until ack
    do_reset();
    intr = 1'b1; step(); intr = 1'b0;
    chk("R10 intr set", irq_recog, 1);
    step(); step();
    chk("R10 intr held", irq_recog, 1);
    intr_ack = 1'b1; step(); intr_ack = 1'b0;
    chk("R10 cleared by ack", irq_recog, 0);

    // R13 hard reset from stop-clock
    do_reset();
    intr = 1'b1; step(); intr = 1'b0;
    enter_grant();
    clk_valid = 1'b0; step();
    hard_rst = 1'b1; stop_req_n = 1'b1; clk_valid = 1'b1; step(); hard_rst = 1'b0;
    chk("R13 state normal", pwr_state, 0);
    chk("R13 irq cleared", irq_recog, 0);

    // R13 hard reset from snoop
    do_reset();
    enter_grant();
    snoop_n = 1'b0; step(); snoop_n = 1'b1;
    hard_rst = 1'b1; stop_req_n = 1'b1; step(); hard_rst = 1'b0;
    chk("R13 from snoop", pwr_state, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule